// File: doc/BRIEF.md
# ADC Input Multiplexer Frame Sequencer

This block time-shares one delta-sigma converter among several analog inputs. It runs from a 32768 Hz clock and works in repeating frames. A frame holds two, three or four mux slots. In each slot the block drives a channel code to the analog mux and pulses a filter-start strobe in the first cycle of the slot. In the last cycle of the slot it pulses a sample-valid strobe, tagged with the same channel code. A slot lasts two or three clock cycles, chosen by a resolution bit.

Software can ask for a single alternate frame by raising a request bit. The rising edge is latched and takes effect at the next frame boundary. Exactly one alternate frame then runs, with temperature in slot 0 and the battery input in slot 3. Slot 1 keeps the line-voltage input so that voltage tracking is never interrupted, and slot 2 also stays unchanged. The block also produces a reference-chop signal that flips once per finished frame, a registered battery-monitor enable, a frame-start strobe, an alternate-frame flag and a sticky flag for illegal frame lengths.

The control path is a three-state slot machine with these states and transitions:
- SL_LAUNCH, the first cycle of a slot. It goes to SL_CAPTURE when the slot is two cycles long and to SL_WAIT otherwise.
- SL_WAIT, the middle cycle or cycles. It goes to SL_CAPTURE in the cycle before the last one.
- SL_CAPTURE, the last cycle of a slot. It always returns to SL_LAUNCH, either for the next slot or for slot 0 of the next frame.

Top module: `adc_mux_sequencer`

## Requirements
- R1: In a regular frame, slots 0, 1, 2 and 3 select channel codes 0 (current A), 1 (voltage A), 2 (current B) and 3 (voltage B).
- R2: In an alternate frame, slot 0 selects code 4 (temperature), slot 1 selects code 1, slot 2 selects code 2 and slot 3 selects code 5 (battery).
- R3: Every frame starts at slot 0 and steps through slots in ascending order until `frame_len` slots are done. `frame_len` and `res_sel` are sampled during reset and in the last cycle of each frame, and they hold for the whole next frame.
- R4: A sampled `frame_len` of 0, 1 or 5 to 7 runs 4-slot frames. Any cycle out of reset with such a value on `frame_len` sets `len_err`, and `len_err` stays set until reset.
- R5: A slot lasts 2 cycles when `res_sel` is 0 and 3 cycles when it is 1. `fir_start` is high in the first cycle of the slot and `smp_valid` is high in the last cycle, and `smp_chan` equals `chan_sel` in that cycle.
- R6: A rising edge on `alt_req`, even one lasting a single cycle, is latched. The frame after the frame in progress is then an alternate frame, and the frame after that is regular again. An edge seen in the last cycle of a frame is served at the following boundary.
- R7: A rising edge on `alt_req` while an alternate frame is pending or running is ignored.
- R8: `frame_start` is high only in the first cycle of slot 0. `alt_active` is high for every cycle of an alternate frame and low in regular frames.
- R9: `vref_chop` is 0 after reset and toggles in the cycle after the last cycle of each frame.
- R10: `batt_mon_en` equals `batt_en` delayed by one cycle, and it is 0 during reset.
- R11: While `rst` is high at a clock edge, the block returns to the first cycle of slot 0 of a regular frame, with no request pending, `len_err` at 0 and `vref_chop` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32768 Hz sequencer clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_len | input | 3 | Slots per frame (2 to 4 are valid) |
| res_sel | input | 1 | 0: 2-cycle slots, 1: 3-cycle slots |
| alt_req | input | 1 | Alternate-frame request, acts on its rising edge |
| batt_en | input | 1 | Battery-monitor enable control |
| chan_sel | output | 3 | Channel code for the analog mux |
| fir_start | output | 1 | Filter-start strobe, first cycle of each slot |
| smp_valid | output | 1 | Conversion-result strobe, last cycle of each slot |
| smp_chan | output | 3 | Channel code that goes with `smp_valid` |
| frame_start | output | 1 | First cycle of slot 0 |
| alt_active | output | 1 | The current frame is an alternate frame |
| vref_chop | output | 1 | Reference-chop control |
| batt_mon_en | output | 1 | Battery-monitor enable |
| len_err | output | 1 | Sticky flag for an illegal frame length |

## Verification
The bench builds the block with its default parameters: 2- and 3-cycle slots and a 3-bit length field. The 3-bit field makes every reserved code (0, 1 and 5 to 7) reachable, as well as all three legal lengths under both slot durations. A behavioural model is compared with the block on every cycle. Request pulses are swept across every cycle offset inside a frame, including the boundary cycle, and further edges are issued while an alternate frame is pending or running.

// File: rtl/adc_mux_pkg.sv
package adc_mux_pkg;

    localparam int CH_W      = 3;
    localparam int MAX_SLOTS = 4;

    typedef enum logic [CH_W-1:0] {
        CH_IA   = 3'd0,
        CH_VA   = 3'd1,
        CH_IB   = 3'd2,
        CH_VB   = 3'd3,
        CH_TEMP = 3'd4,
        CH_VBAT = 3'd5
    } mux_ch_e;

    typedef enum logic [1:0] {
        SL_LAUNCH  = 2'd0,
        SL_WAIT    = 2'd1,
        SL_CAPTURE = 2'd2
    } slot_st_e;

endpackage

// File: rtl/mux_chan_map.sv
module mux_chan_map
    import adc_mux_pkg::*;
#(
    parameter int SLOT_W = 2
) (
    input  logic              alt,
    input  logic [SLOT_W-1:0] slot,
    output logic [CH_W-1:0]   chan
);

    mux_ch_e ch;

    always_comb begin
        unique case (slot)
            SLOT_W'(0): ch = alt ? CH_TEMP : CH_IA;
            SLOT_W'(1): ch = CH_VA;
            SLOT_W'(2): ch = CH_IB;
            SLOT_W'(3): ch = alt ? CH_VBAT : CH_VB;
            default:    ch = CH_IA;
        endcase
    end

    assign chan = ch;

endmodule

// File: rtl/mux_slot_timer.sv
module mux_slot_timer #(
    parameter int CYC_LO = 2,
    parameter int CYC_HI = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic res_hi,
    output logic first,
    output logic pre_last
);

    localparam int CNT_W = $clog2(CYC_HI + 1);
    localparam logic [CNT_W-1:0] DUR_LO = CNT_W'(CYC_LO);
    localparam logic [CNT_W-1:0] DUR_HI = CNT_W'(CYC_HI);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] dur;
    logic             last;

    assign dur      = res_hi ? DUR_HI : DUR_LO;
    assign last     = (cnt == dur - CNT_W'(1));
    assign pre_last = (cnt == dur - CNT_W'(2));
    assign first    = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || last) cnt <= '0;
        else             cnt <= cnt + CNT_W'(1);
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < dur);

endmodule

// File: rtl/mux_alt_ctrl.sv
module mux_alt_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic boundary,
    output logic pending,
    output logic active
);

    logic req_d;
    logic rise;
    logic take;

    assign rise = req && !req_d;
    assign take = rise && !pending && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_d   <= 1'b0;
            pending <= 1'b0;
            active  <= 1'b0;
        end else begin
            req_d <= req;
            if (boundary) begin
                active  <= pending;
                pending <= take;
            end else if (take) begin
                pending <= 1'b1;
            end
        end
    end

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !boundary) |=> pending);

    // R7
    one_alt_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pending, active}));

endmodule

// File: rtl/adc_mux_sequencer.sv
module adc_mux_sequencer
    import adc_mux_pkg::*;
#(
    parameter int LEN_W  = 3,
    parameter int CYC_LO = 2,
    parameter int CYC_HI = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             res_sel,
    input  logic             alt_req,
    input  logic             batt_en,
    output logic [CH_W-1:0]  chan_sel,
    output logic             fir_start,
    output logic             smp_valid,
    output logic [CH_W-1:0]  smp_chan,
    output logic             frame_start,
    output logic             alt_active,
    output logic             vref_chop,
    output logic             batt_mon_en,
    output logic             len_err
);

    localparam int SLOT_W = $clog2(MAX_SLOTS);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_SLOTS);

    slot_st_e          st, st_n;
    logic [SLOT_W-1:0] slot;
    logic [LEN_W-1:0]  eff_len;
    logic              eff_res;
    logic              len_ok;
    logic              last_slot;
    logic              frame_end;
    logic              t_first, t_pre_last;
    logic              alt_pend;
    logic [CH_W-1:0]   chan_w;

    assign len_ok    = (frame_len >= LEN_W'(2)) && (frame_len <= LEN_MAX);
    assign last_slot = (LEN_W'(slot) == eff_len - LEN_W'(1));
    assign frame_end = (st == SL_CAPTURE) && last_slot;

    mux_slot_timer #(.CYC_LO(CYC_LO), .CYC_HI(CYC_HI)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .res_hi   (eff_res),
        .first    (t_first),
        .pre_last (t_pre_last)
    );

    mux_alt_ctrl u_alt (
        .clk      (clk),
        .rst      (rst),
        .req      (alt_req),
        .boundary (frame_end),
        .pending  (alt_pend),
        .active   (alt_active)
    );

    mux_chan_map #(.SLOT_W(SLOT_W)) u_map (
        .alt  (alt_active),
        .slot (slot),
        .chan (chan_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= SL_LAUNCH;
        else     st <= st_n;
    end

    // next-state logic
    always_comb begin
        unique case (st)
            SL_LAUNCH:  st_n = t_pre_last ? SL_CAPTURE : SL_WAIT;
            SL_WAIT:    st_n = t_pre_last ? SL_CAPTURE : SL_WAIT;
            SL_CAPTURE: st_n = SL_LAUNCH;
            default:    st_n = SL_LAUNCH;
        endcase
    end

    // slot index, frame configuration, chop and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            slot        <= '0;
            eff_len     <= len_ok ? frame_len : LEN_MAX;
            eff_res     <= res_sel;
            vref_chop   <= 1'b0;
            len_err     <= 1'b0;
            batt_mon_en <= 1'b0;
        end else begin
            batt_mon_en <= batt_en;
            if (!len_ok) len_err <= 1'b1;
            if (st == SL_CAPTURE) begin
                if (last_slot) slot <= '0;
                else           slot <= slot + SLOT_W'(1);
            end
            if (frame_end) begin
                eff_len   <= len_ok ? frame_len : LEN_MAX;
                eff_res   <= res_sel;
                vref_chop <= !vref_chop;
            end
        end
    end

    // outputs
    always_comb begin
        chan_sel    = chan_w;
        smp_chan    = chan_w;
        fir_start   = (st == SL_LAUNCH);
        smp_valid   = (st == SL_CAPTURE);
        frame_start = (st == SL_LAUNCH) && (slot == '0);
    end

    // R5
    launch_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (st == SL_LAUNCH) == t_first);

    // R5
    strobe_order_chk: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> fir_start);

    // R3
    next_frame_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> frame_start);

    // R8
    alt_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alt_active) |-> frame_start);

    // R2
    va_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_W'(1)) |-> (chan_sel == CH_VA));

    // R9
    chop_flip_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (vref_chop != $past(vref_chop)));

    // R4
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        len_err |=> len_err);

    // R7
    pend_excl_chk: assert property (@(posedge clk) disable iff (rst)
        alt_pend |-> !alt_active);

endmodule

// File: tb/tb_adc_mux_sequencer.sv
module tb_adc_mux_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] frame_len = 3'd4;
    logic       res_sel = 1'b1;
    logic       alt_req = 1'b0;
    logic       batt_en = 1'b0;
    logic [2:0] chan_sel, smp_chan;
    logic       fir_start, smp_valid, frame_start, alt_active;
    logic       vref_chop, batt_mon_en, len_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit started = 0;
    bit done    = 0;

    always #2 clk = ~clk;

    adc_mux_sequencer dut (
        .clk(clk), .rst(rst), .frame_len(frame_len), .res_sel(res_sel),
        .alt_req(alt_req), .batt_en(batt_en), .chan_sel(chan_sel),
        .fir_start(fir_start), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .frame_start(frame_start), .alt_active(alt_active),
        .vref_chop(vref_chop), .batt_mon_en(batt_mon_en), .len_err(len_err)
    );

    // behavioural model state
    int m_slot, m_cyc, m_len, m_dur;
    bit m_pend, m_alt, m_chop, m_err, m_reqd, m_batt, m_rst;

    function automatic int exp_chan(bit a, int s);
        int reg_map[4] = '{0, 1, 2, 3};
        int alt_map[4] = '{4, 1, 2, 5};
        return a ? alt_map[s] : reg_map[s];
    endfunction

    function automatic int pick_len(int fl);
        return (fl >= 2 && fl <= 4) ? fl : 4;
    endfunction

    always @(posedge clk) begin
        bit rise, fend, take;
        m_rst = rst;
        if (rst) begin
            m_slot = 0; m_cyc = 0;
            m_len = pick_len(frame_len); m_dur = res_sel ? 3 : 2;
            m_pend = 0; m_alt = 0; m_chop = 0; m_err = 0; m_reqd = 0; m_batt = 0;
        end else begin
            rise = alt_req && !m_reqd;
            take = rise && !m_pend && !m_alt;
            fend = (m_cyc == m_dur - 1) && (m_slot == m_len - 1);
            if (!(frame_len >= 2 && frame_len <= 4)) m_err = 1;
            if (fend) begin
                m_alt = m_pend;
                m_pend = take;
            end else if (take) m_pend = 1;
            if (m_cyc == m_dur - 1) begin
                m_cyc = 0;
                m_slot = fend ? 0 : m_slot + 1;
            end else m_cyc++;
            if (fend) begin
                m_len = pick_len(frame_len);
                m_dur = res_sel ? 3 : 2;
                m_chop = !m_chop;
            end
            m_reqd = alt_req;
            m_batt = batt_en;
        end
        started = 1;
    end

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            if (m_rst) begin
                chk("R11 reset fir_start", fir_start, 1);
                chk("R11 reset frame_start", frame_start, 1);
                chk("R11 reset alt_active", alt_active, 0);
                chk("R11 reset vref_chop", vref_chop, 0);
                chk("R11 reset len_err", len_err, 0);
                chk("R11 reset chan_sel", chan_sel, 0);
            end else begin
                chk("R5 fir_start", fir_start, m_cyc == 0);
                chk("R5 smp_valid", smp_valid, m_cyc == m_dur - 1);
                chk("R5 smp_chan", smp_chan, exp_chan(m_alt, m_slot));
                chk(m_alt ? "R2 alt chan_sel" : "R1 R3 regular chan_sel",
                    chan_sel, exp_chan(m_alt, m_slot));
                chk("R8 frame_start", frame_start, (m_cyc == 0) && (m_slot == 0));
                chk("R6 R7 R8 alt_active", alt_active, m_alt);
                chk("R9 vref_chop", vref_chop, m_chop);
                chk("R4 len_err", len_err, m_err);
                chk("R10 batt_mon_en", batt_mon_en, m_batt);
            end
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        alt_req = 1'b1;
        run(1);
        alt_req = 1'b0;
    endtask

    initial begin
        run(3);
        rst = 1'b0;
        run(30);
        pulse();                       // R6 single-cycle request
        run(40);
        batt_en = 1'b1;                // R10
        frame_len = 3'd3; res_sel = 1'b0;
        run(30);
        pulse(); run(2); pulse();      // R7 second edge while pending
        run(40);
        alt_req = 1'b1; run(60); alt_req = 1'b0;   // R6 held request: one frame
        frame_len = 3'd2;
        run(20);
        pulse(); run(3); pulse();      // R7 edge while pending or running
        run(30);
        for (int k = 0; k < 14; k++) begin   // R6 edge at every frame offset
            pulse();
            run(20 + k);
        end
        res_sel = 1'b1;
        for (int k = 0; k < 10; k++) begin
            pulse();
            run(25 + k);
        end
        frame_len = 3'd7;              // R4 reserved value
        run(30);
        frame_len = 3'd0;
        run(20);
        frame_len = 3'd3;              // R4 flag stays set
        run(20);
        frame_len = 3'd2; res_sel = 1'b1;
        pulse(); run(4);
        rst = 1'b1;                    // R11 reset mid-run
        run(2);
        rst = 1'b0;
        run(30);
        batt_en = 1'b0;
        frame_len = 3'd1; res_sel = 1'b0;
        run(30);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule